// File: doc/BRIEF.md
# Low-Power Cyclic Wake Controller

This block is the mode controller of a power-management companion chip. A host processor writes a mode code, a wake-period code and a watchdog "always on" bit through a simple register interface; each write arrives as a one-cycle valid pulse. The stop code `3'b111` places the chip in a low-power stop mode. The regulator stays up, the bus transceiver is switched off, and an active-low interconnect line to the host carries a short low strobe once per programmed period of timebase ticks.

A synchronized wake request from the bus receiver or from any monitor input ends the periodic strobing. The interconnect line is then held low until the host sends its next valid command. A bus wake also pulls a receive-line wake indication low. Every source that has requested a wake is latched in a register the host can read.

The watchdog enable follows a load-current flag while in stop mode, unless an always-on bit is set. Every command that changes the mode asks the watchdog for a long first window.

Top module: `cwake_ctrl`

## Requirements
- R1: After reset the mode is active (`3'b000`). `int_n_o` and `rxd_wake_n_o` are high, `wake_src_o` is 0, `xcvr_en_o` and `wd_en_o` are 1, and `wd_long_win_o` is 0.
- R2: A valid command loads mode, period and always-on bit at the clock edge. `xcvr_en_o` is 0 from the next cycle when the mode is `3'b111` (stop), and 1 for any other mode code.
- R3: In stop mode the period code 0, 1, 2, 3 selects 4, 8, 16 or 32 ticks. The tick counter restarts at stop entry. A strobe starts in the cycle after the tick that completes the period, and the next period counts from that tick.
- R4: Each periodic strobe keeps `int_n_o` low for exactly two ticks. The line returns high in the cycle after the second tick that follows the strobe's start.
- R5: In stop mode, a wake request (`bus_wake_i` or any bit of `mon_wake_i`) drives `int_n_o` low from the next cycle. The line stays low, with no periodic strobes, until the cycle after the next valid command. Wake requests outside stop mode have no effect.
- R6: `wake_src_o` bit 0 records a bus wake and bit i+1 records monitor input i. Sources accumulate while the line is held. A valid command clears them, unless a wake arrives in the same cycle. `rxd_wake_n_o` is low while the line is held and bit 0 is set.
- R7: A wake request that arrives during a periodic strobe keeps `int_n_o` low with no high cycle in between.
- R8: `wd_en_o` is registered. It is 1 one cycle after any cycle outside stop mode. In stop mode it equals (always-on bit OR `load_hi_i`), sampled one cycle earlier.
- R9: `wd_long_win_o` pulses high for one cycle, the cycle after a valid command whose mode code differs from the current mode.
- R10: When a held line is released by a command that keeps stop mode, the period restarts in full. The next strobe starts after a full period of ticks counted from the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| cmd_valid_i | input | 1 | Valid register command strobe |
| cmd_mode_i | input | 3 | Mode code; `3'b111` is stop |
| cmd_period_i | input | 2 | Wake-period code (4/8/16/32 ticks) |
| cmd_wd_on_i | input | 1 | Watchdog always-on bit |
| bus_wake_i | input | 1 | Synchronized bus wake request |
| mon_wake_i | input | NMON | Synchronized monitor wake requests |
| load_hi_i | input | 1 | Load current above threshold |
| int_n_o | output | 1 | Active-low interconnect strobe to host |
| rxd_wake_n_o | output | 1 | Active-low bus wake indication on receive line |
| wake_src_o | output | NMON+1 | Latched wake sources, bit 0 = bus |
| xcvr_en_o | output | 1 | Bus transceiver enable |
| wd_en_o | output | 1 | Watchdog enable |
| wd_long_win_o | output | 1 | Long-first-window request pulse |

## Verification
All results come from registers. Mode, transceiver enable, held state, wake sources, receive-line indication, watchdog enable and the long-window pulse therefore show at the outputs in the cycle after the edge that samples the stimulus. A periodic strobe appears one cycle after the tick that completes the period, and it ends one cycle after its second tick. The bench drives inputs at the falling edge and steps its own requirement model just after each rising edge. It compares every output at the next falling edge, so each sample sees exactly one edge of latency. The directed cases use a tick in every cycle, which makes the expected low cycles of each strobe fixed counts from the entry or release edge.

// File: rtl/cwake_pkg.sv
package cwake_pkg;
   localparam int MODE_W = 3;
   typedef logic [MODE_W-1:0] mode_t;
   localparam mode_t MODE_ACTIVE = 3'b000;
   localparam mode_t MODE_STOP   = 3'b111;

   typedef struct packed {
      mode_t mode;
      logic  wd_on;
   } cfg_t;
endpackage

// File: rtl/cwake_cfg_reg.sv
module cwake_cfg_reg
   import cwake_pkg::*;
#(
   parameter int PER_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid_i,
   input  mode_t            cmd_mode_i,
   input  logic [PER_W-1:0] cmd_period_i,
   input  logic             cmd_wd_on_i,
   output cfg_t             cfg_o,
   output logic [PER_W-1:0] period_o,
   output logic             in_stop_o,
   output logic             long_win_o
);
   cfg_t             cfg_q;
   logic [PER_W-1:0] per_q;
   logic             lw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '{mode: MODE_ACTIVE, wd_on: 1'b0};
         per_q <= '0;
         lw_q  <= 1'b0;
      end else begin
         lw_q <= cmd_valid_i && (cmd_mode_i != cfg_q.mode);
         if (cmd_valid_i) begin
            cfg_q.mode  <= cmd_mode_i;
            cfg_q.wd_on <= cmd_wd_on_i;
            per_q       <= cmd_period_i;
         end
      end
   end

   assign cfg_o      = cfg_q;
   assign period_o   = per_q;
   assign in_stop_o  = (cfg_q.mode == MODE_STOP);
   assign long_win_o = lw_q;
endmodule

// File: rtl/cwake_wake_latch.sv
module cwake_wake_latch #(
   parameter int NSRC = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_stop_i,
   input  logic            cmd_valid_i,
   input  logic [NSRC-1:0] req_i,
   output logic            held_o,
   output logic [NSRC-1:0] src_o
);
   logic            any_req;
   logic            held_q;
   logic [NSRC-1:0] src_q;

   assign any_req = in_stop_i && (|req_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            held_q <= 1'b0;
      else if (any_req)      held_q <= 1'b1;
      else if (cmd_valid_i)  held_q <= 1'b0;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          src_q[i] <= 1'b0;
         else if (in_stop_i && req_i[i])      src_q[i] <= 1'b1;
         else if (cmd_valid_i)                src_q[i] <= 1'b0;
      end
   end

   assign held_o = held_q;
   assign src_o  = src_q;
endmodule

// File: rtl/cwake_period_gen.sv
module cwake_period_gen #(
   parameter int PER_W       = 2,
   parameter int BASE_SHIFT  = 2,
   parameter int PULSE_TICKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [PER_W-1:0] period_i,
   output logic             strobe_o
);
   localparam int CNT_W = BASE_SHIFT + (1 << PER_W) - 1;
   localparam int PLS_W = $clog2(PULSE_TICKS + 1);
   localparam logic [PLS_W-1:0] PLS_LOAD = PLS_W'(PULSE_TICKS);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_cnt;
   logic [PLS_W-1:0] pls_q;
   logic             wrap;

   assign last_cnt = CNT_W'((1 << (BASE_SHIFT + int'(period_i))) - 1);
   assign wrap     = run_i && tick_i && (cnt_q >= last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run_i)  cnt_q <= '0;
      else if (wrap)    cnt_q <= '0;
      else if (tick_i)  cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pls_q <= '0;
      else if (!run_i)                pls_q <= '0;
      else if (wrap)                  pls_q <= PLS_LOAD;
      else if (tick_i && pls_q != 0)  pls_q <= pls_q - 1'b1;
   end

   assign strobe_o = (pls_q != 0);
endmodule

// File: rtl/cwake_wd_gate.sv
module cwake_wd_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic in_stop_i,
   input  logic wd_on_i,
   input  logic load_hi_i,
   output logic wd_en_o
);
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b1;
      else        en_q <= !in_stop_i || wd_on_i || load_hi_i;
   end

   assign wd_en_o = en_q;
endmodule

// File: rtl/cwake_ctrl.sv
module cwake_ctrl
   import cwake_pkg::*;
#(
   parameter int NMON        = 4,
   parameter int PER_W       = 2,
   parameter int BASE_SHIFT  = 2,
   parameter int PULSE_TICKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             cmd_valid_i,
   input  logic [2:0]       cmd_mode_i,
   input  logic [PER_W-1:0] cmd_period_i,
   input  logic             cmd_wd_on_i,
   input  logic             bus_wake_i,
   input  logic [NMON-1:0]  mon_wake_i,
   input  logic             load_hi_i,
   output logic             int_n_o,
   output logic             rxd_wake_n_o,
   output logic [NMON:0]    wake_src_o,
   output logic             xcvr_en_o,
   output logic             wd_en_o,
   output logic             wd_long_win_o
);
   localparam int NSRC = NMON + 1;

   if (NMON < 1 || NMON > 16) begin : g_bad_nmon
      $error("cwake_ctrl: NMON must lie in 1..16");
   end
   if (PULSE_TICKS < 1 || PULSE_TICKS >= (1 << BASE_SHIFT)) begin : g_bad_pulse
      $error("cwake_ctrl: PULSE_TICKS must be shorter than the minimum period");
   end
   if (PER_W < 1 || PER_W > 3) begin : g_bad_per
      $error("cwake_ctrl: PER_W must lie in 1..3");
   end

   cfg_t             cfg;
   logic [PER_W-1:0] period;
   logic             in_stop;
   logic             held;
   logic             strobe;
   logic [NSRC-1:0]  src;

   cwake_cfg_reg #(.PER_W(PER_W)) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid_i  (cmd_valid_i),
      .cmd_mode_i   (cmd_mode_i),
      .cmd_period_i (cmd_period_i),
      .cmd_wd_on_i  (cmd_wd_on_i),
      .cfg_o        (cfg),
      .period_o     (period),
      .in_stop_o    (in_stop),
      .long_win_o   (wd_long_win_o)
   );

   cwake_wake_latch #(.NSRC(NSRC)) u_wake (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_stop_i   (in_stop),
      .cmd_valid_i (cmd_valid_i),
      .req_i       ({mon_wake_i, bus_wake_i}),
      .held_o      (held),
      .src_o       (src)
   );

   cwake_period_gen #(
      .PER_W       (PER_W),
      .BASE_SHIFT  (BASE_SHIFT),
      .PULSE_TICKS (PULSE_TICKS)
   ) u_per (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (in_stop && !held),
      .tick_i   (tick_i),
      .period_i (period),
      .strobe_o (strobe)
   );

   cwake_wd_gate u_wd (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_stop_i (in_stop),
      .wd_on_i   (cfg.wd_on),
      .load_hi_i (load_hi_i),
      .wd_en_o   (wd_en_o)
   );

   assign int_n_o      = !(held || strobe);
   assign rxd_wake_n_o = !(held && src[0]);
   assign wake_src_o   = src;
   assign xcvr_en_o    = !in_stop;
endmodule

// File: rtl/cwake_ctrl_chk.sv
module cwake_ctrl_chk #(
   parameter int NMON = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid_i,
   input logic [2:0]      cmd_mode_i,
   input logic            bus_wake_i,
   input logic [NMON-1:0] mon_wake_i,
   input logic            load_hi_i,
   input logic            int_n_o,
   input logic            rxd_wake_n_o,
   input logic            xcvr_en_o,
   input logic            wd_en_o,
   input logic            wd_long_win_o
);
   // R2: a stop command switches the transceiver off in the next cycle
   a_r2_stop_xcvr_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && cmd_mode_i == 3'b111) |=> !xcvr_en_o);

   // R5: a wake request in stop mode pulls the interconnect line low
   a_r5_wake_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!xcvr_en_o && (bus_wake_i || (|mon_wake_i))) |=> !int_n_o);

   // R5: a bus-held line stays held until a command arrives
   a_r5_held_until_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (!rxd_wake_n_o && !cmd_valid_i) |=> !rxd_wake_n_o);

   // R6: the receive-line indication never appears without the held line
   a_r6_rxd_with_int: assert property (@(posedge clk) disable iff (!rst_n)
      !rxd_wake_n_o |-> !int_n_o);

   // R8: load above threshold enables the watchdog next cycle
   a_r8_wd_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_hi_i |=> wd_en_o);

   // R8: outside stop mode the watchdog is enabled next cycle
   a_r8_wd_on_active: assert property (@(posedge clk) disable iff (!rst_n)
      xcvr_en_o |=> wd_en_o);

   // R9: a long-window request always follows a command
   a_r9_lw_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      wd_long_win_o |-> $past(cmd_valid_i));
endmodule

bind cwake_ctrl cwake_ctrl_chk #(.NMON(NMON)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid_i   (cmd_valid_i),
   .cmd_mode_i    (cmd_mode_i),
   .bus_wake_i    (bus_wake_i),
   .mon_wake_i    (mon_wake_i),
   .load_hi_i     (load_hi_i),
   .int_n_o       (int_n_o),
   .rxd_wake_n_o  (rxd_wake_n_o),
   .xcvr_en_o     (xcvr_en_o),
   .wd_en_o       (wd_en_o),
   .wd_long_win_o (wd_long_win_o)
);

// File: tb/cwake_ctrl_tb.sv
`timescale 1ns/1ps
module cwake_ctrl_tb;
   localparam int NMON = 4;
   localparam int NSRC = NMON + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            tick_i = 1'b0;
   logic            cmd_valid_i = 1'b0;
   logic [2:0]      cmd_mode_i = 3'b000;
   logic [1:0]      cmd_period_i = 2'b00;
   logic            cmd_wd_on_i = 1'b0;
   logic            bus_wake_i = 1'b0;
   logic [NMON-1:0] mon_wake_i = '0;
   logic            load_hi_i = 1'b0;
   logic            int_n_o, rxd_wake_n_o, xcvr_en_o, wd_en_o, wd_long_win_o;
   logic [NMON:0]   wake_src_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cwake_ctrl #(.NMON(NMON)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cmd_valid_i(cmd_valid_i),
      .cmd_mode_i(cmd_mode_i), .cmd_period_i(cmd_period_i), .cmd_wd_on_i(cmd_wd_on_i),
      .bus_wake_i(bus_wake_i), .mon_wake_i(mon_wake_i), .load_hi_i(load_hi_i),
      .int_n_o(int_n_o), .rxd_wake_n_o(rxd_wake_n_o), .wake_src_o(wake_src_o),
      .xcvr_en_o(xcvr_en_o), .wd_en_o(wd_en_o), .wd_long_win_o(wd_long_win_o)
   );

   // requirement model state
   logic [2:0]      m_mode;
   logic [1:0]      m_per;
   logic            m_on, m_held, m_wd, m_lw;
   int              m_cnt, m_pls;
   logic [NSRC-1:0] m_src;

   function automatic int period_ticks(logic [1:0] code);
      return 4 << code;
   endfunction

   task automatic model_reset();
      m_mode = 3'b000; m_per = 2'b00; m_on = 1'b0; m_held = 1'b0;
      m_wd = 1'b1; m_lw = 1'b0; m_cnt = 0; m_pls = 0; m_src = '0;
   endtask

   task automatic model_step();
      logic            stop, wake, trig, n_held;
      logic [NSRC-1:0] req, n_src;
      int              n_cnt, n_pls;
      stop = (m_mode == 3'b111);
      req  = {mon_wake_i, bus_wake_i};
      wake = stop && (|req);
      n_held = m_held; n_src = m_src;
      if (cmd_valid_i) begin n_held = 1'b0; n_src = '0; end
      if (wake) begin
         n_held = 1'b1;
         n_src  = (cmd_valid_i ? '0 : m_src) | req;
      end
      trig = 1'b0;
      n_cnt = m_cnt; n_pls = m_pls;
      if (!stop || m_held) begin n_cnt = 0; n_pls = 0; end
      else begin
         if (tick_i) begin
            if (m_cnt >= period_ticks(m_per) - 1) begin n_cnt = 0; trig = 1'b1; end
            else n_cnt = m_cnt + 1;
         end
         if (trig) n_pls = 2;
         else if (tick_i && m_pls != 0) n_pls = m_pls - 1;
      end
      m_wd = !stop || m_on || load_hi_i;
      m_lw = cmd_valid_i && (cmd_mode_i != m_mode);
      if (cmd_valid_i) begin m_mode = cmd_mode_i; m_per = cmd_period_i; m_on = cmd_wd_on_i; end
      m_held = n_held; m_src = n_src; m_cnt = n_cnt; m_pls = n_pls;
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_model();
      chk("R4", 32'(int_n_o), 32'(!(m_held || m_pls != 0)), "int_n model");
      chk("R6", 32'(rxd_wake_n_o), 32'(!(m_held && m_src[0])), "rxd model");
      chk("R6", 32'(wake_src_o), 32'(m_src), "src model");
      chk("R2", 32'(xcvr_en_o), 32'(m_mode != 3'b111), "xcvr model");
      chk("R8", 32'(wd_en_o), 32'(m_wd), "wd model");
      chk("R9", 32'(wd_long_win_o), 32'(m_lw), "longwin model");
   endtask

   // one clock: model steps after the rising edge, outputs compared at the falling edge
   task automatic cyc();
      @(posedge clk);
      #1;
      if (rst_n) model_step(); else model_reset();
      @(negedge clk);
      compare_model();
   endtask

   task automatic send_cmd(logic [2:0] mode, logic [1:0] per, logic on);
      cmd_valid_i = 1'b1; cmd_mode_i = mode; cmd_period_i = per; cmd_wd_on_i = on;
      cyc();
      cmd_valid_i = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 1234;
      void'($urandom(seed));
      model_reset();
      repeat (3) cyc();
      // R1: reset state
      chk("R1", 32'(int_n_o), 1, "int_n reset");
      chk("R1", 32'(rxd_wake_n_o), 1, "rxd reset");
      chk("R1", 32'(wake_src_o), 0, "src reset");
      chk("R1", 32'(xcvr_en_o), 1, "xcvr reset");
      chk("R1", 32'(wd_en_o), 1, "wd reset");
      chk("R1", 32'(wd_long_win_o), 0, "longwin reset");
      rst_n = 1'b1;
      cyc();

      // R3 R4: period code 0 with a tick every cycle
      tick_i = 1'b1;
      send_cmd(3'b111, 2'b00, 1'b0);
      chk("R2", 32'(xcvr_en_o), 0, "stop entry");
      chk("R9", 32'(wd_long_win_o), 1, "longwin on entry");
      for (int k = 1; k <= 8; k++) begin
         cyc();
         chk((k == 4 || k == 8) ? "R3" : "R4", 32'(int_n_o),
             32'(!(k == 4 || k == 5 || k == 8)), $sformatf("strobe pattern k=%0d", k));
         if (k == 2) chk("R8", 32'(wd_en_o), 0, "wd off in stop, low load");
      end
      // R7: bus wake during the strobe
      bus_wake_i = 1'b1;
      cyc();
      bus_wake_i = 1'b0;
      chk("R7", 32'(int_n_o), 0, "no gap on wake in strobe");
      chk("R6", 32'(rxd_wake_n_o), 0, "rxd low on bus wake");
      chk("R6", 32'(wake_src_o), 1, "bus source bit");
      for (int k = 0; k < 6; k++) begin
         cyc();
         chk("R5", 32'(int_n_o), 0, "held low until command");
      end
      // R10: release in stop, full period restarts
      send_cmd(3'b111, 2'b00, 1'b0);
      chk("R5", 32'(int_n_o), 1, "released by command");
      chk("R6", 32'(wake_src_o), 0, "sources cleared");
      chk("R9", 32'(wd_long_win_o), 0, "no longwin for same mode");
      for (int k = 1; k <= 4; k++) begin
         cyc();
         chk("R10", 32'(int_n_o), 32'(k != 4), $sformatf("restart k=%0d", k));
      end
      // R6: monitor source bit
      mon_wake_i = 4'b0100;
      cyc();
      mon_wake_i = '0;
      chk("R6", 32'(wake_src_o), 32'h8, "monitor 2 source bit");
      chk("R6", 32'(rxd_wake_n_o), 1, "rxd high for monitor wake");
      // R8: load above threshold
      load_hi_i = 1'b1;
      cyc();
      chk("R8", 32'(wd_en_o), 1, "wd on with load");
      load_hi_i = 1'b0;
      // leave stop, then wake outside stop is ignored
      send_cmd(3'b000, 2'b00, 1'b0);
      chk("R2", 32'(xcvr_en_o), 1, "active mode");
      chk("R9", 32'(wd_long_win_o), 1, "longwin on exit");
      bus_wake_i = 1'b1; mon_wake_i = 4'b1111;
      cyc();
      bus_wake_i = 1'b0; mon_wake_i = '0;
      cyc();
      chk("R5", 32'(int_n_o), 1, "wake ignored outside stop");
      chk("R5", 32'(wake_src_o), 0, "no source outside stop");

      // constrained random phase against the requirement model
      for (int n = 0; n < 4000; n++) begin
         tick_i      = ($urandom_range(0, 2) == 0);
         cmd_valid_i = ($urandom_range(0, 39) == 0);
         cmd_mode_i  = ($urandom_range(0, 1) == 0) ? 3'b111 : 3'($urandom_range(0, 7));
         cmd_period_i = 2'($urandom_range(0, 3));
         cmd_wd_on_i = ($urandom_range(0, 3) == 0);
         bus_wake_i  = ($urandom_range(0, 79) == 0);
         mon_wake_i  = ($urandom_range(0, 59) == 0) ? NMON'(1 << $urandom_range(0, NMON-1)) : '0;
         if ($urandom_range(0, 29) == 0) load_hi_i = !load_hi_i;
         cyc();
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule